// File: doc/BRIEF.md
# Store Queue with Load Disambiguation

This block holds the stores of an out-of-order core in program order, in a circular buffer, from dispatch until they are written to the data cache. Every store that enters at the tail receives an age, which is the current value of a dispatch counter. The counter advances by one for each store accepted. The store's address and its data arrive later, each separately and addressed by slot, as the execute stage produces them. Once the retire logic signals that the oldest store may perform, the entry at the head is written to the cache and released.

The block also answers disambiguation queries from a load that is in its cache-access stage. The load presents an age and an address. In the same cycle, every store older than the load is examined in parallel. The load is held if any of those older stores has no address yet. Otherwise the block finds the youngest older store whose address equals the load's. In bypass-only mode, such a match holds the load. In forwarding mode, the matching store's data is handed back, or the load is held if that data has not arrived. If no older store matches, the load keeps the value it read from the cache. The load queue and the cache are outside this block.

A load obtains its age by sampling `alloc_age` at the moment it dispatches. That value is the number of stores dispatched ahead of it. `DEPTH` must be a power of two.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_age` is 0, `cache_wr_valid` is 0, and any query returns `ld_wait`=0, `ld_fwd_hit`=0, `ld_fwd_data`=0.
- R2: While `alloc_ready` is 1, an `alloc_valid` cycle stores an entry in slot `alloc_slot` (which equals `alloc_age` modulo DEPTH), stamped with `alloc_age`, and `alloc_age` then rises by exactly one. When DEPTH entries are live, `alloc_ready` is 0 and `alloc_valid` changes nothing.
- R3: An address write or a data write names a slot and marks only that part of the entry as known. Writes to a slot that holds no live store are ignored.
- R4: When `retire_en` is 1 and the head entry has both its address and its data, `cache_wr_valid` is 1 with the head's address and data, and the head is freed at that clock edge. In every other case `cache_wr_valid` is 0 and the head stays.
- R5: A live store with age S is older than a load with age L exactly when (L − S) mod 2^(log2(DEPTH)+1) lies in 1..DEPTH. For a correctly stamped load, this means the stores dispatched before it.
- R6: If any older store has an unknown address, `ld_wait` is 1 and `ld_fwd_hit` is 0, in both modes.
- R7: With `fwd_mode`=0 (bypass only), an older store whose known address equals `ld_addr` sets `ld_wait` to 1. `ld_fwd_hit` is never 1 in this mode.
- R8: With `fwd_mode`=1, when the youngest older store with a matching address has its data, `ld_fwd_hit` is 1, `ld_wait` is 0 and `ld_fwd_data` carries that store's data.
- R9: With `fwd_mode`=1, when the youngest older matching store has no data yet, `ld_wait` is 1, even if an older matching store does have data.
- R10: When all older addresses are known and none matches, `ld_wait` and `ld_fwd_hit` are 0 and `ld_fwd_data` is 0. `ld_fwd_data` is 0 whenever `ld_fwd_hit` is 0.
- R11: Stores with an age equal to or younger than the load's have no effect on the query result, whatever their address state.
- R12: The query outputs and the cache write outputs are combinational functions of the current queue state and the inputs of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch a store at the tail |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_slot | output | log2(DEPTH) | Slot the next dispatched store takes |
| alloc_age | output | log2(DEPTH)+1 | Age the next store takes; also the age a dispatching load samples |
| addr_wr_valid | input | 1 | Store address write |
| addr_wr_slot | input | log2(DEPTH) | Slot for the address write |
| addr_wr_addr | input | ADDR_W | Store address |
| data_wr_valid | input | 1 | Store data write |
| data_wr_slot | input | log2(DEPTH) | Slot for the data write |
| data_wr_data | input | DATA_W | Store data |
| retire_en | input | 1 | Oldest store is at the reorder-buffer head and may perform |
| cache_wr_valid | output | 1 | Head store written to the cache this cycle |
| cache_wr_addr | output | ADDR_W | Cache write address |
| cache_wr_data | output | DATA_W | Cache write data |
| fwd_mode | input | 1 | 0 = bypass only, 1 = bypass with forwarding |
| ld_age | input | log2(DEPTH)+1 | Age of the querying load |
| ld_addr | input | ADDR_W | Address of the querying load |
| ld_wait | output | 1 | Load must not complete this cycle |
| ld_fwd_hit | output | 1 | Load takes `ld_fwd_data` instead of cache data |
| ld_fwd_data | output | DATA_W | Forwarded store data |

## Verification
The bench targets the age boundary in three ways. It checks a load aged exactly at a store's age, which must treat that store as younger. It checks loads after the counter has wrapped several times. It checks a full queue, where all DEPTH stores are older. A wrong comparison here would either hold a load behind its own younger stores or forward from them. The bench also builds two older stores that alias: the younger one lacks data and the older one has it. A selector that picks the oldest match, or any match, would forward stale data instead of waiting. Finally, it checks that an unresolved older address holds the load in forwarding mode even when a younger store matches, and it tries to allocate while the queue is full, where a wrong design would overwrite a live entry.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

  typedef enum logic [1:0] {
    LDV_CACHE   = 2'd0,
    LDV_WAIT    = 2'd1,
    LDV_FORWARD = 2'd2
  } ld_verdict_e;

  typedef enum logic {
    MODE_BYPASS  = 1'b0,
    MODE_FORWARD = 1'b1
  } disamb_mode_e;

endpackage

// File: rtl/sfq_ptrs.sv
module sfq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AGE_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [AGE_W-1:0] next_age,
  output logic             full,
  output logic             empty
);

  localparam logic [IDX_W:0] CNT_FULL = (IDX_W+1)'(DEPTH);

  logic [IDX_W:0]   count_q, count_d;
  logic [IDX_W-1:0] head_q, head_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic             upd_en;

  always_comb begin
    count_d = count_q;
    head_d  = head_q;
    age_d   = age_q;
    if (push) begin
      age_d = age_q + 1'b1;
    end
    if (pop) begin
      head_d = head_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  assign upd_en = push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      head_q  <= '0;
      age_q   <= '0;
    end else if (upd_en) begin
      count_q <= count_d;
      head_q  <= head_d;
      age_q   <= age_d;
    end
  end

  assign head_idx = head_q;
  assign tail_idx = age_q[IDX_W-1:0];
  assign next_age = age_q;
  assign full     = (count_q == CNT_FULL);
  assign empty    = (count_q == '0);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_FULL);

  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  assert_push_not_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/sfq_entries.sv
module sfq_entries #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AGE_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic [AGE_W-1:0]  alloc_age,
  input  logic              free_fire,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic              aw_valid,
  input  logic [IDX_W-1:0]  aw_slot,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              dw_valid,
  input  logic [IDX_W-1:0]  dw_slot,
  input  logic [DATA_W-1:0] dw_data,
  output logic              e_valid [DEPTH],
  output logic [AGE_W-1:0]  e_age   [DEPTH],
  output logic              e_aok   [DEPTH],
  output logic [ADDR_W-1:0] e_addr  [DEPTH],
  output logic              e_dok   [DEPTH],
  output logic [DATA_W-1:0] e_data  [DEPTH]
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              val_q, val_d;
    logic              aok_q, aok_d;
    logic              dok_q, dok_d;
    logic [AGE_W-1:0]  age_q, age_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic              alloc_here, free_here, aw_here, dw_here, en;

    assign alloc_here = alloc_fire && (tail_idx == IDX_W'(g));
    assign free_here  = free_fire  && (head_idx == IDX_W'(g));
    assign aw_here    = aw_valid && val_q && (aw_slot == IDX_W'(g));
    assign dw_here    = dw_valid && val_q && (dw_slot == IDX_W'(g));
    assign en         = alloc_here | free_here | aw_here | dw_here;

    always_comb begin
      val_d  = val_q;
      aok_d  = aok_q;
      dok_d  = dok_q;
      age_d  = age_q;
      addr_d = addr_q;
      data_d = data_q;
      if (alloc_here) begin
        val_d = 1'b1;
        aok_d = 1'b0;
        dok_d = 1'b0;
        age_d = alloc_age;
      end else begin
        if (free_here) begin
          val_d = 1'b0;
        end
        if (aw_here) begin
          aok_d  = 1'b1;
          addr_d = aw_addr;
        end
        if (dw_here) begin
          dok_d  = 1'b1;
          data_d = dw_data;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q  <= 1'b0;
        aok_q  <= 1'b0;
        dok_q  <= 1'b0;
        age_q  <= '0;
        addr_q <= '0;
        data_q <= '0;
      end else if (en) begin
        val_q  <= val_d;
        aok_q  <= aok_d;
        dok_q  <= dok_d;
        age_q  <= age_d;
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end

    assign e_valid[g] = val_q;
    assign e_age[g]   = age_q;
    assign e_aok[g]   = aok_q;
    assign e_addr[g]  = addr_q;
    assign e_dok[g]   = dok_q;
    assign e_data[g]  = data_q;

    // R2: allocation never lands on a live entry
    assert_alloc_free_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_here |-> !val_q);

    // R4: only a fully resolved head is released
    assert_free_resolved_R4: assert property (@(posedge clk) disable iff (!rst_n)
      free_here |-> (val_q && aok_q && dok_q));
  end

endmodule

// File: rtl/sfq_search.sv
module sfq_search
  import sfq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AGE_W = IDX_W + 1
) (
  input  logic              e_valid [DEPTH],
  input  logic [AGE_W-1:0]  e_age   [DEPTH],
  input  logic              e_aok   [DEPTH],
  input  logic [ADDR_W-1:0] e_addr  [DEPTH],
  input  logic              e_dok   [DEPTH],
  input  logic [DATA_W-1:0] e_data  [DEPTH],
  input  disamb_mode_e      mode,
  input  logic [AGE_W-1:0]  ld_age,
  input  logic [ADDR_W-1:0] ld_addr,
  output ld_verdict_e       verdict,
  output logic [DATA_W-1:0] fwd_data
);

  localparam logic [AGE_W-1:0] SPAN = AGE_W'(DEPTH);

  logic [AGE_W-1:0] diff_v  [DEPTH];
  logic             older_v [DEPTH];
  logic             unk_v   [DEPTH];
  logic             match_v [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign diff_v[g]  = ld_age - e_age[g];
    assign older_v[g] = e_valid[g] && (diff_v[g] != '0) && (diff_v[g] <= SPAN);
    assign unk_v[g]   = older_v[g] && !e_aok[g];
    assign match_v[g] = older_v[g] && e_aok[g] && (e_addr[g] == ld_addr);
  end

  logic             any_unk;
  logic             found;
  logic [AGE_W-1:0] best_diff;
  logic [IDX_W-1:0] best_idx;

  // Youngest older match is the one nearest the load: smallest age distance.
  always_comb begin
    any_unk   = 1'b0;
    found     = 1'b0;
    best_diff = '1;
    best_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (unk_v[i]) begin
        any_unk = 1'b1;
      end
      if (match_v[i] && (!found || (diff_v[i] < best_diff))) begin
        found     = 1'b1;
        best_diff = diff_v[i];
        best_idx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (any_unk) begin
      verdict = LDV_WAIT;
    end else if (!found) begin
      verdict = LDV_CACHE;
    end else if (mode == MODE_BYPASS) begin
      verdict = LDV_WAIT;
    end else if (e_dok[best_idx]) begin
      verdict = LDV_FORWARD;
    end else begin
      verdict = LDV_WAIT;
    end
  end

  assign fwd_data = (verdict == LDV_FORWARD) ? e_data[best_idx] : '0;

endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
  import sfq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AGE_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_slot,
  output logic [AGE_W-1:0]  alloc_age,
  input  logic              addr_wr_valid,
  input  logic [IDX_W-1:0]  addr_wr_slot,
  input  logic [ADDR_W-1:0] addr_wr_addr,
  input  logic              data_wr_valid,
  input  logic [IDX_W-1:0]  data_wr_slot,
  input  logic [DATA_W-1:0] data_wr_data,
  input  logic              retire_en,
  output logic              cache_wr_valid,
  output logic [ADDR_W-1:0] cache_wr_addr,
  output logic [DATA_W-1:0] cache_wr_data,
  input  logic              fwd_mode,
  input  logic [AGE_W-1:0]  ld_age,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_wait,
  output logic              ld_fwd_hit,
  output logic [DATA_W-1:0] ld_fwd_data
);

  logic             full, empty;
  logic             alloc_fire, free_fire;
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic [AGE_W-1:0] next_age;

  logic              e_valid [DEPTH];
  logic [AGE_W-1:0]  e_age   [DEPTH];
  logic              e_aok   [DEPTH];
  logic [ADDR_W-1:0] e_addr  [DEPTH];
  logic              e_dok   [DEPTH];
  logic [DATA_W-1:0] e_data  [DEPTH];

  ld_verdict_e  verdict;
  disamb_mode_e mode;

  assign alloc_fire = alloc_valid && !full;
  assign free_fire  = retire_en && e_valid[head_idx] && e_aok[head_idx] && e_dok[head_idx];

  sfq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (alloc_fire),
    .pop      (free_fire),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .next_age (next_age),
    .full     (full),
    .empty    (empty)
  );

  sfq_entries #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entries (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .tail_idx   (tail_idx),
    .alloc_age  (next_age),
    .free_fire  (free_fire),
    .head_idx   (head_idx),
    .aw_valid   (addr_wr_valid),
    .aw_slot    (addr_wr_slot),
    .aw_addr    (addr_wr_addr),
    .dw_valid   (data_wr_valid),
    .dw_slot    (data_wr_slot),
    .dw_data    (data_wr_data),
    .e_valid    (e_valid),
    .e_age      (e_age),
    .e_aok      (e_aok),
    .e_addr     (e_addr),
    .e_dok      (e_dok),
    .e_data     (e_data)
  );

  assign mode = disamb_mode_e'(fwd_mode);

  sfq_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_search (
    .e_valid  (e_valid),
    .e_age    (e_age),
    .e_aok    (e_aok),
    .e_addr   (e_addr),
    .e_dok    (e_dok),
    .e_data   (e_data),
    .mode     (mode),
    .ld_age   (ld_age),
    .ld_addr  (ld_addr),
    .verdict  (verdict),
    .fwd_data (ld_fwd_data)
  );

  assign alloc_ready    = !full;
  assign alloc_slot     = tail_idx;
  assign alloc_age      = next_age;
  assign cache_wr_valid = free_fire;
  assign cache_wr_addr  = e_addr[head_idx];
  assign cache_wr_data  = e_data[head_idx];
  assign ld_wait        = (verdict == LDV_WAIT);
  assign ld_fwd_hit     = (verdict == LDV_FORWARD);

  assert_age_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (alloc_age == $past(alloc_age) + 1'b1));

  assert_age_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_fire |=> $stable(alloc_age));

  assert_retire_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cache_wr_valid |-> (retire_en && !empty));

  assert_hit_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fwd_hit |-> !ld_wait);

  assert_bypass_nofwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_mode |-> !ld_fwd_hit);

  assert_data_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_fwd_hit |-> (ld_fwd_data == '0));

endmodule

// File: tb/tb_store_fwd_queue.sv
`timescale 1ns/1ps
module tb_store_fwd_queue;

  localparam int DEPTH  = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;
  localparam int AGE_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_valid, alloc_ready;
  logic [IDX_W-1:0]  alloc_slot;
  logic [AGE_W-1:0]  alloc_age;
  logic              addr_wr_valid;
  logic [IDX_W-1:0]  addr_wr_slot;
  logic [ADDR_W-1:0] addr_wr_addr;
  logic              data_wr_valid;
  logic [IDX_W-1:0]  data_wr_slot;
  logic [DATA_W-1:0] data_wr_data;
  logic              retire_en;
  logic              cache_wr_valid;
  logic [ADDR_W-1:0] cache_wr_addr;
  logic [DATA_W-1:0] cache_wr_data;
  logic              fwd_mode;
  logic [AGE_W-1:0]  ld_age;
  logic [ADDR_W-1:0] ld_addr;
  logic              ld_wait, ld_fwd_hit;
  logic [DATA_W-1:0] ld_fwd_data;

  store_fwd_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model, kept by position from the head
  bit              m_val [DEPTH];
  bit              m_aok [DEPTH];
  bit              m_dok [DEPTH];
  bit [ADDR_W-1:0] m_addr[DEPTH];
  bit [DATA_W-1:0] m_data[DEPTH];
  int              m_head = 0;
  int              m_cnt  = 0;
  int              m_next = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected query result from program order: slot positions relative to head.
  task automatic model_query(output bit e_wait, output bit e_hit,
                             output bit [DATA_W-1:0] e_data, output string tag);
    int  lpos;
    int  best;
    bit  unk;
    bit  younger;
    lpos = (int'(ld_age) - (m_next - m_cnt)) & ((1 << AGE_W) - 1);
    best = -1; unk = 0; younger = 0;
    for (int p = 0; p < m_cnt; p++) begin
      int s;
      s = (m_head + p) % DEPTH;
      if (p < lpos) begin
        if (!m_aok[s]) unk = 1;
        else if (m_addr[s] == ld_addr) best = s;
      end else begin
        younger = 1;
      end
    end
    e_wait = 0; e_hit = 0; e_data = '0;
    if (unk) begin
      e_wait = 1; tag = "R6";
    end else if (best < 0) begin
      tag = "R10";
    end else if (!fwd_mode) begin
      e_wait = 1; tag = "R7";
    end else if (m_dok[best]) begin
      e_hit = 1; e_data = m_data[best]; tag = "R8";
    end else begin
      e_wait = 1; tag = "R9";
    end
    if (younger) tag = {tag, "/R11/R5"};
  endtask

  // Called just after a falling edge with inputs driven; checks, then applies one clock edge.
  task automatic step();
    bit e_wait, e_hit, e_cw;
    bit [DATA_W-1:0] e_data;
    string tag;
    int hs;
    #1;
    model_query(e_wait, e_hit, e_data, tag);
    check(ld_wait == e_wait, tag, "ld_wait (R12)", ld_wait, e_wait);
    check(ld_fwd_hit == e_hit, tag, "ld_fwd_hit", ld_fwd_hit, e_hit);
    check(ld_fwd_data == e_data, tag, "ld_fwd_data", ld_fwd_data, e_data);
    check(alloc_ready == (m_cnt < DEPTH), "R2", "alloc_ready", alloc_ready, m_cnt < DEPTH);
    check(alloc_age == AGE_W'(m_next), "R2", "alloc_age", alloc_age, m_next & 15);
    check(alloc_slot == IDX_W'(m_next), "R2", "alloc_slot", alloc_slot, m_next & 7);
    hs   = m_head;
    e_cw = retire_en && m_cnt > 0 && m_aok[hs] && m_dok[hs];
    check(cache_wr_valid == e_cw, "R4", "cache_wr_valid", cache_wr_valid, e_cw);
    if (e_cw) begin
      check(cache_wr_addr == m_addr[hs], "R4/R3", "cache_wr_addr", cache_wr_addr, m_addr[hs]);
      check(cache_wr_data == m_data[hs], "R4/R3", "cache_wr_data", cache_wr_data, m_data[hs]);
    end
    @(posedge clk);
    if (addr_wr_valid && m_val[addr_wr_slot]) begin
      m_aok[addr_wr_slot] = 1; m_addr[addr_wr_slot] = addr_wr_addr;
    end
    if (data_wr_valid && m_val[data_wr_slot]) begin
      m_dok[data_wr_slot] = 1; m_data[data_wr_slot] = data_wr_data;
    end
    if (e_cw) begin
      m_val[hs] = 0; m_head = (m_head + 1) % DEPTH; m_cnt--;
    end
    if (alloc_valid && (m_cnt + (e_cw ? 1 : 0)) < DEPTH) begin
      int t;
      t = m_next % DEPTH;
      m_val[t] = 1; m_aok[t] = 0; m_dok[t] = 0;
      m_next++; m_cnt++;
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; addr_wr_valid = 0; data_wr_valid = 0; retire_en = 0;
    addr_wr_slot = '0; addr_wr_addr = '0; data_wr_slot = '0; data_wr_data = '0;
    fwd_mode = 1; ld_age = AGE_W'(m_next); ld_addr = 16'h0100;
  endtask

  function automatic bit [ADDR_W-1:0] pick_addr();
    return 16'h0100 + ADDR_W'(($urandom % 4) * 4);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: reset state, observed during reset and just after release
    #1;
    check(alloc_ready == 1, "R1", "alloc_ready", alloc_ready, 1);
    check(alloc_age == 0, "R1", "alloc_age", alloc_age, 0);
    check(cache_wr_valid == 0, "R1", "cache_wr_valid", cache_wr_valid, 0);
    check(ld_wait == 0 && ld_fwd_hit == 0 && ld_fwd_data == 0, "R1", "query", ld_wait, 0);
    rst_n = 1;
    @(negedge clk);
    step();

    // Fill beyond capacity: the extra allocations must be ignored (R2)
    for (int k = 0; k < DEPTH + 3; k++) begin
      idle_inputs(); alloc_valid = 1; ld_age = AGE_W'(m_next); step();
    end
    // Slots 2 and 5 alias address A, others get B; only slot 2 has data
    for (int k = 0; k < DEPTH; k++) begin
      idle_inputs();
      addr_wr_valid = 1; addr_wr_slot = IDX_W'(k);
      addr_wr_addr  = (k == 2 || k == 5) ? 16'h0A00 : 16'h0B00 + ADDR_W'(k);
      if (k == 2) begin data_wr_valid = 1; data_wr_slot = 3'd2; data_wr_data = 32'hCAFE_0002; end
      step();
    end
    // R9: youngest older match (slot 5) lacks data although slot 2 has it
    idle_inputs(); ld_age = 4'd8; ld_addr = 16'h0A00; step();
    // R8: load aged 5 sees slot 2 only (R5 boundary: slot 5 is equal age)
    idle_inputs(); ld_age = 4'd5; ld_addr = 16'h0A00; step();
    // R7: bypass mode with the same match
    idle_inputs(); ld_age = 4'd5; ld_addr = 16'h0A00; fwd_mode = 0; step();
    // R10: no match
    idle_inputs(); ld_age = 4'd8; ld_addr = 16'h0C00; step();
    // R3: write to slot data while retiring blocked by missing data
    idle_inputs(); retire_en = 1; step();
    for (int k = 0; k < DEPTH; k++) begin
      idle_inputs(); data_wr_valid = 1; data_wr_slot = IDX_W'(k);
      data_wr_data = 32'hD000_0000 + DATA_W'(k); step();
    end
    for (int k = 0; k < DEPTH + 2; k++) begin
      idle_inputs(); retire_en = 1; ld_age = AGE_W'(m_next); step();
    end
    // R3: a write to an empty slot is ignored (queue is empty now)
    idle_inputs(); addr_wr_valid = 1; addr_wr_slot = 3'd4; addr_wr_addr = 16'h0100; step();
    idle_inputs(); alloc_valid = 1; step();
    idle_inputs(); ld_age = AGE_W'(m_next); step();

    // Constrained random traffic
    for (int it = 0; it < 6000; it++) begin
      idle_inputs();
      alloc_valid = ($urandom % 100) < 45;
      retire_en   = ($urandom % 100) < 35;
      if (m_cnt > 0) begin
        if (($urandom % 100) < 45) begin
          addr_wr_valid = 1;
          addr_wr_slot  = IDX_W'(m_head + int'($urandom % m_cnt));
          addr_wr_addr  = pick_addr();
        end
        if (($urandom % 100) < 40) begin
          data_wr_valid = 1;
          data_wr_slot  = IDX_W'(m_head + int'($urandom % m_cnt));
          data_wr_data  = $urandom;
        end
      end
      if (($urandom % 100) < 5) begin
        addr_wr_valid = 1; addr_wr_slot = IDX_W'($urandom); addr_wr_addr = pick_addr();
      end
      fwd_mode = ($urandom % 100) < 75;
      ld_age   = AGE_W'((m_next - m_cnt) + int'($urandom % (m_cnt + 1)));
      ld_addr  = pick_addr();
      step();
    end

    finish_run();
  end

endmodule